// File: doc/BRIEF.md
# Dual-Side Interrupt Status Register

This block holds a 32-bit interrupt status word for a bus bridge. Its two users sit on opposite sides of the bridge: an external host and an internal processor. Twelve event lines from the bridge logic each set a sticky flag in the low part of the word. A host interrupt line stays asserted while any set flag is not blocked by a mask. The host reads the word in one cycle, and that read clears every bit on the following clock edge.

The upper sixteen bits form a doorbell field that software defines. When the host writes a one into any of these bits, the bit is set and an interrupt goes to the internal processor. That interrupt falls when a host read clears the doorbell bits. Bits 15:12 always read as zero.

A mode input selects host or device operation. The device-interrupt flag and the system-error flag can be set only in host mode. An event that arrives in the same cycle as a clearing read is kept.

Top module: `dual_irq_status`

## Requirements
- R1: While reset is asserted and after it is released, `hostRdData` reads 0 and both `hostIrq` and `cpuIrq` are low.
- R2: A one-cycle pulse on `eventIn[i]` sets status bit i for i in 0..9. The bit stays set until a host read clears it.
- R3: A pulse on `swResetWr` sets status bit 7, the software-reset request flag, just as `eventIn[7]` does.
- R4: Bits 11 (device interrupt seen) and 10 (system error seen) follow `eventIn[11]` and `eventIn[10]` only while `hostMode` is 1. While `hostMode` is 0, those pulses leave both bits at 0.
- R5: Bits 15:12 always read 0. A host write to them has no effect, and a host write to bits 11:0 has no effect either.
- R6: A host write (`hostWrEn`) sets every doorbell bit 31:16 that is 1 in `hostWrData[31:16]`. Doorbell bits written as 0 keep their value.
- R7: `hostRdData` shows the current status in the same cycle as `hostRdEn`. All 32 bits are 0 in the next cycle unless something set them in that read cycle.
- R8: An event pulse, or a doorbell write, in the same cycle as `hostRdEn` survives the clear. Its bit is 1 in the next cycle.
- R9: `hostIrq` is 1 exactly when some status bit is 1 and the matching `intMask` bit is 0. A mask bit of 1 blocks its status bit.
- R10: `cpuIrq` is 1 exactly when any doorbell bit 31:16 is set. It falls in the cycle after a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostMode | input | 1 | 1 = host mode, 0 = device mode |
| eventIn | input | 12 | One-cycle event pulses, bit i sets status bit i |
| swResetWr | input | 1 | Strobe for a host write to the software-reset register |
| hostRdEn | input | 1 | Host read of the status word (clears it at the next edge) |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data, only bits 31:16 are used |
| intMask | input | 32 | Host interrupt mask, 1 blocks the bit |
| hostRdData | output | 32 | Current status word |
| hostIrq | output | 1 | Level interrupt toward the host |
| cpuIrq | output | 1 | Level interrupt toward the internal processor |

## Verification
An event pulse, a software-reset strobe or a doorbell write shows up in `hostRdData` one clock edge after the cycle in which it is driven. Both interrupt outputs follow the stored word combinationally in that same cycle. A read returns the stored word in its own cycle, and the cleared word appears one edge later. The bench drives every input at a falling edge and holds it for one full cycle. It samples the read value while `hostRdEn` is still high, and it samples every later result at the next falling edge, so each check falls exactly one register stage after its stimulus.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int EVT_W      = 12;
  localparam int RSV_W      = 4;
  localparam int DB_W       = 16;
  localparam int REG_W      = DB_W + RSV_W + EVT_W;
  localparam int DB_LSB     = EVT_W + RSV_W;
  localparam int DEVINT_BIT = 11;
  localparam int SYSERR_BIT = 10;
  localparam int SWRST_BIT  = 7;

  typedef struct packed {
    logic             clearAll;
    logic [EVT_W-1:0] evtSet;
    logic [DB_W-1:0]  dbSet;
  } strobe_t;
endpackage

// File: rtl/dirq_ctrl.sv
module dirq_ctrl
  import dirq_pkg::*;
(
  input  logic                 hostMode,
  input  logic [EVT_W-1:0]     eventIn,
  input  logic                 swResetWr,
  input  logic                 hostRdEn,
  input  logic                 hostWrEn,
  input  logic [REG_W-1:0]     hostWrData,
  output strobe_t              strobes
);
  logic [EVT_W-1:0] evtGate;
  logic             unusedWrLow;

  // Host-only flags are gated by the mode, and the reset strobe joins its flag.
  for (genvar i = 0; i < EVT_W; i++) begin : g_gate
    if (i == DEVINT_BIT || i == SYSERR_BIT) begin : g_hostOnly
      assign evtGate[i] = eventIn[i] & hostMode;
    end else if (i == SWRST_BIT) begin : g_swrst
      assign evtGate[i] = eventIn[i] | swResetWr;
    end else begin : g_plain
      assign evtGate[i] = eventIn[i];
    end
  end

  assign unusedWrLow = ^hostWrData[DB_LSB-1:0];

  always_comb begin
    strobes.clearAll = hostRdEn;
    strobes.evtSet   = evtGate;
    strobes.dbSet    = hostWrEn ? hostWrData[REG_W-1:DB_LSB] : '0;
  end
endmodule

// File: rtl/dirq_datapath.sv
module dirq_datapath
  import dirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] intMask,
  output logic [REG_W-1:0] statusWord,
  output logic             hostIrq,
  output logic             cpuIrq
);
  logic [EVT_W-1:0] evtQ;
  logic [DB_W-1:0]  dbQ;

  // The clear happens first and the set strobes are ORed in after it, so a new set is kept.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ <= '0;
      dbQ  <= '0;
    end else begin
      evtQ <= (strobes.clearAll ? '0 : evtQ) | strobes.evtSet;
      dbQ  <= (strobes.clearAll ? '0 : dbQ)  | strobes.dbSet;
    end
  end

  assign statusWord = {dbQ, {RSV_W{1'b0}}, evtQ};
  assign hostIrq    = |(statusWord & ~intMask);
  assign cpuIrq     = |dbQ;
endmodule

// File: rtl/dual_irq_status.sv
module dual_irq_status
  import dirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostMode,
  input  logic [11:0]      eventIn,
  input  logic             swResetWr,
  input  logic             hostRdEn,
  input  logic             hostWrEn,
  input  logic [31:0]      hostWrData,
  input  logic [31:0]      intMask,
  output logic [31:0]      hostRdData,
  output logic             hostIrq,
  output logic             cpuIrq
);
  strobe_t strobes;

  dirq_ctrl u_ctrl (
    .hostMode   (hostMode),
    .eventIn    (eventIn),
    .swResetWr  (swResetWr),
    .hostRdEn   (hostRdEn),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .strobes    (strobes)
  );

  dirq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .intMask    (intMask),
    .statusWord (hostRdData),
    .hostIrq    (hostIrq),
    .cpuIrq     (cpuIrq)
  );
endmodule

// File: rtl/dual_irq_status_chk.sv
module dual_irq_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostMode,
  input logic [11:0] eventIn,
  input logic        swResetWr,
  input logic        hostRdEn,
  input logic        hostWrEn,
  input logic [31:0] intMask,
  input logic [31:0] hostRdData,
  input logic        hostIrq,
  input logic        cpuIrq
);
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[15:12] == 4'h0);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> ((hostRdData & $past(hostRdData)) == $past(hostRdData)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && eventIn == 12'h0 && !swResetWr && !hostWrEn) |=> hostRdData == 32'h0);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && eventIn[0]) |=> hostRdData[0]);

  // R4
  device_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostMode && hostRdData[11:10] == 2'b00) |=> hostRdData[11:10] == 2'b00);

  // R9
  host_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq == ((hostRdData & ~intMask) != 32'h0));

  // R10
  cpu_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (hostRdData[31:16] != 16'h0));
endmodule

bind dual_irq_status dual_irq_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostMode   (hostMode),
  .eventIn    (eventIn),
  .swResetWr  (swResetWr),
  .hostRdEn   (hostRdEn),
  .hostWrEn   (hostWrEn),
  .intMask    (intMask),
  .hostRdData (hostRdData),
  .hostIrq    (hostIrq),
  .cpuIrq     (cpuIrq)
);

// File: tb/dual_irq_status_tb.sv
`timescale 1ns/1ps
module dual_irq_status_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostMode = 1'b1;
  logic [11:0] eventIn = '0;
  logic        swResetWr = 1'b0;
  logic        hostRdEn = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] intMask = '0;
  logic [31:0] hostRdData;
  logic        hostIrq;
  logic        cpuIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_irq_status u_dut (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .eventIn(eventIn),
    .swResetWr(swResetWr), .hostRdEn(hostRdEn), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .intMask(intMask), .hostRdData(hostRdData),
    .hostIrq(hostIrq), .cpuIrq(cpuIrq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulseEvt(input logic [11:0] ev);
    @(negedge clk); eventIn = ev;
    @(negedge clk); eventIn = '0;
  endtask

  task automatic hostWrite(input logic [31:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0; hostWrData = '0;
  endtask

  task automatic hostRead(output logic [31:0] v);
    @(negedge clk); hostRdEn = 1'b1;
    #0.5 v = hostRdData;
    @(negedge clk); hostRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 reset data", hostRdData, 32'h0);
    check("R1 reset irq", {30'h0, hostIrq, cpuIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {hostRdData[29:0], hostIrq, cpuIrq}, 32'h0);

    // R2 / R4: each event bit alone in host mode
    for (int i = 0; i < 12; i++) begin
      pulseEvt(12'h1 << i);
      @(negedge clk);
      check(i >= 10 ? "R4 host-mode flag kept" : "R2 sticky flag", hostRdData, 32'h1 << i);
      check("R9 irq unmasked", {31'h0, hostIrq}, 32'h1);
      hostRead(v);
      check("R7 read value", v, 32'h1 << i);
      check("R7 cleared", hostRdData, 32'h0);
    end

    // R3 software-reset strobe
    @(negedge clk); swResetWr = 1'b1;
    @(negedge clk); swResetWr = 1'b0;
    hostRead(v);
    check("R3 swreset flag", v, 32'h0000_0080);

    // R4 device mode blocks bits 11:10
    hostMode = 1'b0;
    pulseEvt(12'hFFF);
    hostRead(v);
    check("R4 device mode", v, 32'h0000_03FF);
    pulseEvt(12'hC00);
    check("R4 device mode only host bits", hostRdData, 32'h0);
    hostMode = 1'b1;

    // R5 writes to reserved and event bits ignored
    hostWrite(32'h0000_FFFF);
    check("R5 low write ignored", hostRdData, 32'h0);
    check("R5 no irq", {30'h0, hostIrq, cpuIrq}, 32'h0);

    // R6 / R10 doorbell sweep
    for (int j = 0; j < 16; j++) begin
      hostWrite(32'h1 << (16 + j));
      check("R6 doorbell set", hostRdData, 32'h1 << (16 + j));
      check("R10 cpu irq", {31'h0, cpuIrq}, 32'h1);
      hostRead(v);
      check("R10 cpu irq drops", {31'h0, cpuIrq}, 32'h0);
    end
    hostWrite(32'h0001_0000);
    hostWrite(32'h0002_0000);
    hostWrite(32'h0000_0000);
    hostRead(v);
    check("R6 accumulate", v, 32'h0003_0000);

    // R9 mask sweep
    for (int k = 0; k < 12; k++) begin
      pulseEvt(12'h1 << k);
      intMask = 32'h1 << k;
      #0.5 check("R9 masked", {31'h0, hostIrq}, 32'h0);
      intMask = ~(32'h1 << k);
      #0.5 check("R9 other mask bits", {31'h0, hostIrq}, 32'h1);
      intMask = '0;
      hostRead(v);
    end
    intMask = 32'hFFFF_FFFF;
    hostWrite(32'h8000_0000);
    check("R9 doorbell masked", {30'h0, hostIrq, cpuIrq}, 32'h1);
    intMask = '0;
    hostRead(v);

    // R8 events and writes during a clearing read
    pulseEvt(12'h001);
    @(negedge clk); hostRdEn = 1'b1; eventIn = 12'h008; hostWrEn = 1'b1; hostWrData = 32'h0100_0000;
    #0.5 v = hostRdData;
    @(negedge clk); hostRdEn = 1'b0; eventIn = '0; hostWrEn = 1'b0; hostWrData = '0;
    check("R7 read during collision", v, 32'h0000_0001);
    check("R8 event wins", hostRdData, 32'h0100_0008);
    hostRead(v);
    check("R7 final clear", hostRdData, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule